// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial-link PHY out of reset and then confirms that its receive PLL has settled. It sits above a PHY control-bus handshake master and drives it through a small command/response interface. Each command carries an operation code and a 16-bit value, and the master answers each non-posted command with a done strobe, an error flag and 16 bits of read data.

A one-cycle start pulse launches the sequence. The sequencer first addresses the PHY clock/reset register and posts a reset write to it. The PHY cannot acknowledge that write while it is resetting, so the sequencer does not wait for an answer. It then runs a bounded number of lock checks. Each check waits a settle delay, addresses the lane status register and reads it. The sequence ends in one of three ways: the PLL is seen locked, every attempt is used up, or the handshake layer reports an error. In every case `done_o` pulses once. The locked flag or the matching error flag stays up until the next accepted start.

Top module: `phy_lock_seq`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_valid_o`, `done_o`, `locked_o`, `err_timeout_o` and `err_bus_o` are all 0 until a start is accepted.
- R2: A start pulse accepted while idle makes the next cycle present command op 0 (address) with value 0x7F3F. After that command is answered without error, the following cycle presents op 1 (posted write) with value 0x0001.
- R3: The posted write is presented for exactly one cycle and needs no response. A done or error strobe from the handshake layer during that cycle has no effect on the sequence.
- R4: Before the address phase of every lock check, including the first, the command interface is idle for exactly SETTLE_CYC cycles.
- R5: A lock check is an address command (op 0, value 0x2003) followed, once that is answered, by a read command (op 2, value 0x0000). A non-posted command holds its op and value until it is answered.
- R6: Only bit LOCK_BIT (bit 1) of the data returned for the read of a lock check decides lock. Data returned for an address command is never taken as lock.
- R7: If MAX_TRIES (10) lock checks all read the lock bit as 0, the sequence ends with `err_timeout_o` set and `locked_o` clear, after exactly MAX_TRIES checks.
- R8: A response with the error flag set to any non-posted command ends the sequence at once with `err_bus_o` set, and no further command is issued.
- R9: `done_o` is a one-cycle pulse in the cycle after the response that ends the sequence.
- R10: `locked_o`, `err_timeout_o` and `err_bus_o` change only when a sequence ends or when a start is accepted. At most one of them is set, and an accepted start clears all three.
- R11: A start pulse arriving while a sequence is running is ignored: the command stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| cmd_valid_o | output | 1 | Command presented to the handshake master |
| cmd_op_o | output | 2 | Operation: 0 address, 1 posted write, 2 read |
| cmd_val_o | output | DATA_W | Register address or write value |
| rsp_done_i | input | 1 | Handshake master finished the current command |
| rsp_err_i | input | 1 | Handshake master reports failure, valid with done |
| rsp_rdata_i | input | DATA_W | Read data, valid with done |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| locked_o | output | 1 | Receive PLL was seen locked |
| err_timeout_o | output | 1 | All lock checks failed |
| err_bus_o | output | 1 | Handshake layer reported an error |

## Verification
The hardest situations to reach from the ports are lock on the very last permitted check and the full run of checks that never locks. Both depend on the count of read responses with bit 1 low, not on timing. The bench's responder therefore chooses, per run, which read returns 0x0002 and returns 0xFFFD for every other read, so every other bit is set and only the decisive bit is clear. It also answers address commands with bit 1 set, and it can inject an error at any response index or a spurious error strobe during the posted write. A second start pulse is placed in the middle of a long run to show that it is ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [1:0] {
      CMD_ADDR = 2'd0,
      CMD_POST = 2'd1,
      CMD_READ = 2'd2
   } cmd_op_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_ADDR,
      ST_RST_POST,
      ST_SETTLE,
      ST_CHK_ADDR,
      ST_CHK_READ
   } seq_state_t;

   typedef enum logic [1:0] {
      END_NONE,
      END_LOCK,
      END_TIMEOUT,
      END_BUSERR
   } seq_end_t;

endpackage

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   generate
      if (CYCLES == 1) begin : g_single
         assign expire_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run_i || expire_o)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign expire_o = run_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/seq_try_counter.sv
module seq_try_counter #(
   parameter int MAX_TRIES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   generate
      if (MAX_TRIES == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(MAX_TRIES);
         localparam logic [TW-1:0] LAST = TW'(MAX_TRIES - 1);
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr_i)
               cnt_q <= '0;
            else if (inc_i)
               cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/seq_cmd_gen.sv
module seq_cmd_gen
   import phy_seq_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter logic [DATA_W-1:0] RST_REG  = 16'h7F3F,
   parameter logic [DATA_W-1:0] RST_VAL  = 16'h0001,
   parameter logic [DATA_W-1:0] LANE_REG = 16'h2003
) (
   input  seq_state_t        state_i,
   output logic              valid_o,
   output cmd_op_t           op_o,
   output logic [DATA_W-1:0] val_o
);
   always_comb begin
      valid_o = 1'b1;
      op_o    = CMD_ADDR;
      val_o   = '0;
      unique case (state_i)
         ST_RST_ADDR: val_o = RST_REG;
         ST_RST_POST: begin
            op_o  = CMD_POST;
            val_o = RST_VAL;
         end
         ST_CHK_ADDR: val_o = LANE_REG;
         ST_CHK_READ: op_o = CMD_READ;
         default:     valid_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
   import phy_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int SETTLE_CYC = 20,
   parameter int MAX_TRIES  = 10,
   parameter int LOCK_BIT   = 1,
   parameter logic [DATA_W-1:0] RST_REG  = 16'h7F3F,
   parameter logic [DATA_W-1:0] RST_VAL  = 16'h0001,
   parameter logic [DATA_W-1:0] LANE_REG = 16'h2003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              cmd_valid_o,
   output logic [1:0]        cmd_op_o,
   output logic [DATA_W-1:0] cmd_val_o,
   input  logic              rsp_done_i,
   input  logic              rsp_err_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   output logic              done_o,
   output logic              locked_o,
   output logic              err_timeout_o,
   output logic              err_bus_o
);
   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (LOCK_BIT >= DATA_W || LOCK_BIT < 0) begin : g_bad_bit
         $error("LOCK_BIT must index into the read data");
      end
   endgenerate

   seq_state_t state_q, state_d;
   seq_end_t   end_kind;
   cmd_op_t    op_w;
   logic       settle_done, try_last, try_inc, accept, busy;
   logic       done_q, locked_q, tmo_q, bus_q;
   logic       unused_rdata;

   assign unused_rdata = ^rsp_rdata_i;
   assign accept       = (state_q == ST_IDLE) && start_i;
   assign busy         = (state_q != ST_IDLE);

   seq_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (state_q == ST_SETTLE),
      .expire_o (settle_done)
   );

   seq_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .inc_i  (try_inc),
      .last_o (try_last)
   );

   seq_cmd_gen #(
      .DATA_W   (DATA_W),
      .RST_REG  (RST_REG),
      .RST_VAL  (RST_VAL),
      .LANE_REG (LANE_REG)
   ) u_cmd (
      .state_i (state_q),
      .valid_o (cmd_valid_o),
      .op_o    (op_w),
      .val_o   (cmd_val_o)
   );
   assign cmd_op_o = op_w;

   always_comb begin
      state_d  = state_q;
      end_kind = END_NONE;
      try_inc  = 1'b0;
      unique case (state_q)
         ST_IDLE:     if (start_i) state_d = ST_RST_ADDR;
         ST_RST_ADDR: if (rsp_done_i) begin
            if (rsp_err_i) end_kind = END_BUSERR;
            else           state_d  = ST_RST_POST;
         end
         ST_RST_POST: state_d = ST_SETTLE;
         ST_SETTLE:   if (settle_done) state_d = ST_CHK_ADDR;
         ST_CHK_ADDR: if (rsp_done_i) begin
            if (rsp_err_i) end_kind = END_BUSERR;
            else           state_d  = ST_CHK_READ;
         end
         ST_CHK_READ: if (rsp_done_i) begin
            if (rsp_err_i)                  end_kind = END_BUSERR;
            else if (rsp_rdata_i[LOCK_BIT]) end_kind = END_LOCK;
            else if (try_last)              end_kind = END_TIMEOUT;
            else begin
               try_inc = 1'b1;
               state_d = ST_SETTLE;
            end
         end
         default:     state_d = ST_IDLE;
      endcase
      if (end_kind != END_NONE) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         done_q   <= 1'b0;
         locked_q <= 1'b0;
         tmo_q    <= 1'b0;
         bus_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (end_kind != END_NONE);
         if (accept) begin
            locked_q <= 1'b0;
            tmo_q    <= 1'b0;
            bus_q    <= 1'b0;
         end else begin
            if (end_kind == END_LOCK)    locked_q <= 1'b1;
            if (end_kind == END_TIMEOUT) tmo_q    <= 1'b1;
            if (end_kind == END_BUSERR)  bus_q    <= 1'b1;
         end
      end
   end

   assign done_o        = done_q;
   assign locked_o      = locked_q;
   assign err_timeout_o = tmo_q;
   assign err_bus_o     = bus_q;
endmodule

// File: rtl/phy_lock_seq_chk.sv
module phy_lock_seq_chk #(
   parameter int DATA_W   = 16,
   parameter int LOCK_BIT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy,
   input logic              cmd_valid_o,
   input logic [1:0]        cmd_op_o,
   input logic [DATA_W-1:0] cmd_val_o,
   input logic              rsp_done_i,
   input logic              rsp_err_i,
   input logic [DATA_W-1:0] rsp_rdata_i,
   input logic              done_o,
   input logic              locked_o,
   input logic              err_timeout_o,
   input logic              err_bus_o
);
   // R2
   start_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> (cmd_valid_o && cmd_op_o == 2'd0 && cmd_val_o == 16'h7F3F));

   // R3
   post_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o == 2'd1) |=> !(cmd_valid_o && cmd_op_o == 2'd1));

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o != 2'd1 && !rsp_done_i)
      |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_val_o)));

   // R6
   lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> ($past(rsp_done_i) && $past(rsp_rdata_i[LOCK_BIT])
                           && $past(cmd_op_o) == 2'd2));

   // R8
   bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_op_o != 2'd1 && rsp_done_i && rsp_err_i)
      |=> (done_o && err_bus_o && !cmd_valid_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_i) |=> $stable({locked_o, err_timeout_o, err_bus_o}));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({locked_o, err_timeout_o, err_bus_o}) <= 1);
endmodule

bind phy_lock_seq phy_lock_seq_chk #(.DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .busy          (busy),
   .cmd_valid_o   (cmd_valid_o),
   .cmd_op_o      (cmd_op_o),
   .cmd_val_o     (cmd_val_o),
   .rsp_done_i    (rsp_done_i),
   .rsp_err_i     (rsp_err_i),
   .rsp_rdata_i   (rsp_rdata_i),
   .done_o        (done_o),
   .locked_o      (locked_o),
   .err_timeout_o (err_timeout_o),
   .err_bus_o     (err_bus_o)
);

// File: tb/phy_lock_seq_test.sv
`timescale 1ns/1ps
module phy_lock_seq_test;
   localparam int SETTLE = 5;
   localparam int TRIES  = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cmd_valid_o;
   logic [1:0]  cmd_op_o;
   logic [15:0] cmd_val_o;
   logic        rsp_done_i = 1'b0;
   logic        rsp_err_i = 1'b0;
   logic [15:0] rsp_rdata_i = '0;
   logic        done_o, locked_o, err_timeout_o, err_bus_o;

   always #2.5 clk = ~clk;

   phy_lock_seq #(.SETTLE_CYC(SETTLE), .MAX_TRIES(TRIES)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_val_o(cmd_val_o),
      .rsp_done_i(rsp_done_i), .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i),
      .done_o(done_o), .locked_o(locked_o),
      .err_timeout_o(err_timeout_o), .err_bus_o(err_bus_o)
   );

   int vectors = 0;
   int fails   = 0;
   bit finished = 0;

   // scenario configuration and responder state
   int cfg_lat = 0, cfg_lock_at = -1, cfg_err_at = -1;
   bit cfg_spur = 0;
   int resp_idx = 0, wait_cnt = 0, last_term = 0; // 1 lock, 2 timeout, 3 bus

   // reference model state
   int          exp_op[$];
   logic [15:0] exp_val[$];
   bit running = 0, exp_lock = 0, exp_tmo = 0, exp_bus = 0;
   bit prev_valid = 0;
   logic [1:0] prev_op = 2'd0;
   int idle_cnt = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // responder standing in for the handshake master
   initial begin
      forever begin
         @(negedge clk); #1;
         rsp_done_i = 0; rsp_err_i = 0; rsp_rdata_i = '0; last_term = 0;
         if (!rst_n) wait_cnt = 0;
         else if (cmd_valid_o && cmd_op_o != 2'd1) begin
            if (wait_cnt >= cfg_lat) begin
               wait_cnt = 0;
               rsp_done_i = 1;
               if (resp_idx == cfg_err_at) begin
                  rsp_err_i = 1; last_term = 3;
               end else if (cmd_op_o == 2'd2) begin
                  if ((resp_idx - 2) / 2 == cfg_lock_at) begin
                     rsp_rdata_i = 16'h0002; last_term = 1;
                  end else begin
                     rsp_rdata_i = 16'hFFFD;
                     if ((resp_idx - 2) / 2 == TRIES - 1) last_term = 2;
                  end
               end else rsp_rdata_i = 16'h0002; // address answers carry bit 1 (R6)
               resp_idx++;
            end else wait_cnt++;
         end else begin
            wait_cnt = 0;
            if (cmd_valid_o && cmd_op_o == 2'd1 && cfg_spur) begin
               rsp_done_i = 1; rsp_err_i = 1; // stray strobe on posted write (R3)
            end
         end
      end
   end

   // per-cycle comparison against the model
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            check({cmd_valid_o, done_o, locked_o, err_timeout_o, err_bus_o} == 5'b0,
                  "R1", "outputs in reset", {cmd_valid_o, done_o, locked_o, err_timeout_o, err_bus_o}, 0);
            prev_valid = 0;
         end else begin
            bit exp_done, newcmd;
            if (start_i && !running) begin
               running = 1; exp_lock = 0; exp_tmo = 0; exp_bus = 0; idle_cnt = 0;
            end
            exp_done = rsp_done_i && (last_term != 0);
            if (exp_done) begin
               running = 0;
               exp_lock = (last_term == 1);
               exp_tmo  = (last_term == 2);
               exp_bus  = (last_term == 3);
               check(exp_op.size() == 0, "R7", "commands left at end (R8)", exp_op.size(), 0);
            end
            check(done_o == exp_done, "R9", "done_o", done_o, exp_done);
            check(locked_o == exp_lock, "R6", "locked_o (R10)", locked_o, exp_lock);
            check(err_timeout_o == exp_tmo, "R7", "err_timeout_o (R10)", err_timeout_o, exp_tmo);
            check(err_bus_o == exp_bus, "R8", "err_bus_o (R10)", err_bus_o, exp_bus);
            newcmd = cmd_valid_o && (!prev_valid || rsp_done_i || prev_op == 2'd1);
            if (!running) check(!cmd_valid_o, "R11", "cmd_valid_o while idle", cmd_valid_o, 0);
            else if (newcmd) begin
               if (exp_op.size() == 0)
                  check(0, "R11", "unexpected command", {cmd_op_o, cmd_val_o}, 0);
               else begin
                  int eo; logic [15:0] ev;
                  eo = exp_op.pop_front(); ev = exp_val.pop_front();
                  check(cmd_op_o == eo[1:0] && cmd_val_o == ev, "R2", "command op/value (R5)",
                        {cmd_op_o, cmd_val_o}, {eo[1:0], ev});
                  if (eo == 0 && ev == 16'h2003)
                     check(idle_cnt == SETTLE, "R4", "settle gap", idle_cnt, SETTLE);
               end
               idle_cnt = 0;
            end else if (!cmd_valid_o) idle_cnt++;
            prev_valid = cmd_valid_o;
            prev_op    = cmd_op_o;
         end
      end
   end

   task automatic build_queue(input int lock_at, input int err_at);
      exp_op.delete(); exp_val.delete();
      exp_op.push_back(0); exp_val.push_back(16'h7F3F);
      if (err_at == 0) return;
      exp_op.push_back(1); exp_val.push_back(16'h0001);
      for (int t = 0; t < TRIES; t++) begin
         exp_op.push_back(0); exp_val.push_back(16'h2003);
         if (err_at == 1 + 2 * t) return;
         exp_op.push_back(2); exp_val.push_back(16'h0000);
         if (err_at == 2 + 2 * t || t == lock_at) return;
      end
   endtask

   task automatic run(input int lat, input int lock_at, input int err_at,
                      input bit spur, input int busy_start_at);
      int guard;
      cfg_lat = lat; cfg_lock_at = lock_at; cfg_err_at = err_at; cfg_spur = spur;
      resp_idx = 0;
      build_queue(lock_at, err_at);
      @(negedge clk); #1 start_i = 1;
      @(negedge clk); #1 start_i = 0;
      if (busy_start_at > 0) begin
         repeat (busy_start_at) @(negedge clk);
         #1 start_i = 1;   // R11: ignored while running
         @(negedge clk); #1 start_i = 0;
      end
      guard = 0;
      while (!done_o && guard < 3000) begin
         @(negedge clk); guard++;
      end
      if (guard >= 3000) check(0, "R9", "sequence never ended", 0, 1);
      repeat (6) @(negedge clk);  // flags must hold meanwhile (R10)
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1;
      repeat (4) @(negedge clk);
      run(0, 0, -1, 0, 0);          // lock at first check
      run(2, 3, -1, 1, 0);          // lock on fourth check, stray strobe on posted write (R3)
      run(1, -1, -1, 0, 0);         // never locks: timeout after all checks (R7)
      run(0, TRIES - 1, -1, 0, 0);  // lock on the last permitted check
      run(1, -1, 0, 0, 0);          // error on reset address (R8)
      run(0, -1, 6, 0, 0);          // error on third lock-check read (R8)
      run(0, -1, 3, 0, 0);          // error on second lock-check address (R8)
      run(1, 5, -1, 0, 12);         // start pulse mid-run ignored (R11)
      run(3, 2, -1, 1, 3);          // long latency with both disturbances
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired (R9) actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule